// File: doc/BRIEF.md
# Receive FIFO Front End with Programmable Level Flags

This block buffers 32-bit words arriving on a parallel input port and hands them to software through a small word-addressed register bus. Software turns reception on, programs two level thresholds, and then reads words one at a time from a data register. Each read of that register removes the oldest word. Four live level flags show the fill state as active-high "not" conditions. Two sticky error bits record a word lost to a full FIFO and a read attempted on an empty one.

An interrupt unit watches four level conditions: empty, almost empty, almost full and full. It latches a pending bit on each rising edge of a condition. Software clears a pending bit by writing 1 to it. A per-source enable mask selects which pending bits drive the interrupt line. A board-reset command clears every register and empties the FIFO. It then holds the FIFO untouchable for a settling window counted in clock cycles. A separate FIFO-reset command empties only the storage.

Top module: `rxf_frontend`

Register word addresses: 0 control, 1 status, 2 thresholds, 3 data, 4 interrupt enable, 5 interrupt pending, 6 size, 7 fill level.

## Requirements
- R1: Writing control with bit 0 set clears the control, threshold, interrupt-enable and interrupt-pending registers and both error bits. It also empties the FIFO. Bit 0 always reads back 0.
- R2: For SETTLE cycles after a board-reset command, input words and data-register reads have no effect, and the fill level stays 0. After the window, words are accepted again.
- R3: Writing control with bit 2 set empties the FIFO. The threshold and interrupt-enable registers keep their values. Bit 2 reads back 0, and the enable bit 5 takes the written value.
- R4: A word on `in_data` with `in_valid` high is stored only while control bit 5 is 1. Reads of address 3 return the stored words in arrival order.
- R5: Status bit 12 is 1 when the fill count is above 0. Bit 13 is 1 when the count is above the almost-empty level. Bit 14 is 1 when count plus the almost-full level is below DEPTH. Bit 15 is 1 when the count is below DEPTH.
- R6: The threshold register holds the almost-empty level in bits 15:0 and the almost-full level in bits 23:16. Both read back as written.
- R7: A word offered while the FIFO is full is dropped, the fill count does not change, and status bit 23 is set. Bit 23 stays set until a status write with bit 23 at 1.
- R8: A data read while the FIFO is empty returns 0, leaves the count at 0 and sets status bit 22. Bit 22 stays set until a status write with bit 22 at 1.
- R9: Pending bits 12, 13, 14 and 15 (empty, almost empty, almost full, full) are set one cycle after their condition goes from false to true. A condition that stays true does not set the bit again. Writing 1 to a pending bit clears it.
- R10: `irq` is 1 exactly when some pending bit and its enable bit (same position, 12 to 15) are both 1.
- R11: The size register returns DEPTH in bits 19:0. The level register returns the current fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 32 | Input word |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the data address) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the FIFO past full and drains it past empty. A design that let the extra word in, or that popped stale data, would show a wrong level or a word out of order in the scoreboard. It holds conditions true across a pending-bit clear; a level-triggered design would raise the pending bit again at once. It runs a FIFO reset with thresholds programmed and a board reset followed by early input. A design that cleared the thresholds, or that let input in during the settling window, would show a nonzero level or lost thresholds.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_STAT   = 3'd1,
        REG_THRESH = 3'd2,
        REG_DATA   = 3'd3,
        REG_IEN    = 3'd4,
        REG_IPEND  = 3'd5,
        REG_SIZE   = 3'd6,
        REG_LEVEL  = 3'd7
    } reg_addr_e;

    localparam int CTRL_BOARD_RST = 0;
    localparam int CTRL_FIFO_RST  = 2;
    localparam int CTRL_RX_EN     = 5;
    localparam int STAT_UNDER     = 22;
    localparam int STAT_OVER      = 23;
    localparam int LVL_LSB        = 12;

    // packed as {full, almost_full, almost_empty, empty} -> bits 15..12
    typedef struct packed {
        logic full;
        logic almost_full;
        logic almost_empty;
        logic empty;
    } lvl_t;

    function automatic lvl_t calc_levels(int unsigned cnt, int unsigned ae,
                                         int unsigned af, int unsigned depth);
        lvl_t r;
        r.empty        = (cnt == 0);
        r.almost_empty = (cnt <= ae);
        r.almost_full  = (cnt + af >= depth);
        r.full         = (cnt >= depth);
        return r;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout = mem[rd_ptr];

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R4
    push_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/rxf_irq.sv
module rxf_irq #(
    parameter int N                   = 4,
    parameter logic [N-1:0] PREV_INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_all,
    input  logic [N-1:0] src,
    input  logic         w1c_we,
    input  logic [N-1:0] w1c_bits,
    input  logic [N-1:0] en,
    output logic [N-1:0] pend,
    output logic         irq
);
    logic [N-1:0] prev;

    for (genvar k = 0; k < N; k++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || clear_all) begin
                prev[k] <= PREV_INIT[k];
                pend[k] <= 1'b0;
            end else begin
                prev[k] <= src[k];
                if (src[k] && !prev[k])
                    pend[k] <= 1'b1;
                else if (w1c_we && w1c_bits[k])
                    pend[k] <= 1'b0;
            end
        end

        // R9
        rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
            ($rose(src[k]) && !clear_all && !$past(clear_all)) |=> pend[k]);
    end

    assign irq = |(pend & en);

endmodule

// File: rtl/rxf_frontend.sv
module rxf_frontend #(
    parameter int DW     = 32,
    parameter int DEPTH  = 16,
    parameter int SETTLE = 8,
    localparam int CW    = $clog2(DEPTH) + 1,
    localparam int BW    = $clog2(SETTLE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    import rxf_pkg::*;

    logic          rx_en;
    logic [15:0]   ae_lvl;
    logic [7:0]    af_lvl;
    logic [3:0]    ien;
    logic          ovr, und;
    logic [BW-1:0] busy_cnt;
    logic [CW-1:0] count;
    logic [DW-1:0] head;
    logic [3:0]    pend;
    lvl_t          lv;

    logic wr_ctrl, wr_stat, board_rst, flush, busy;
    logic push, pop, ovr_evt, und_evt, data_rd;
    logic unused_bits;

    assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
    assign wr_stat   = bus_wr && (bus_addr == REG_STAT);
    assign board_rst = wr_ctrl && bus_wdata[CTRL_BOARD_RST];
    assign flush     = board_rst || (wr_ctrl && bus_wdata[CTRL_FIFO_RST]);
    assign busy      = (busy_cnt != '0);

    assign lv = calc_levels(32'(count), 32'(ae_lvl), 32'(af_lvl), DEPTH);

    assign push    = in_valid && rx_en && !busy && !lv.full;
    assign ovr_evt = in_valid && rx_en && !busy && lv.full;
    assign data_rd = bus_rd && (bus_addr == REG_DATA) && !busy;
    assign pop     = data_rd && !lv.empty;
    assign und_evt = data_rd && lv.empty;

    assign unused_bits = ^bus_wdata[31:24];

    rxf_store #(.W(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
        .din(in_data), .dout(head), .count(count)
    );

    rxf_irq #(.N(4), .PREV_INIT(4'b0011)) u_irq (
        .clk(clk), .rst(rst), .clear_all(board_rst), .src(lv),
        .w1c_we(bus_wr && (bus_addr == REG_IPEND)),
        .w1c_bits(bus_wdata[LVL_LSB+3:LVL_LSB]),
        .en(ien), .pend(pend), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst || board_rst) begin
            rx_en    <= 1'b0;
            ae_lvl   <= '0;
            af_lvl   <= '0;
            ien      <= '0;
            ovr      <= 1'b0;
            und      <= 1'b0;
            busy_cnt <= board_rst ? BW'(SETTLE) : '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (wr_ctrl) rx_en <= bus_wdata[CTRL_RX_EN];
            if (bus_wr && bus_addr == REG_THRESH) begin
                ae_lvl <= bus_wdata[15:0];
                af_lvl <= bus_wdata[23:16];
            end
            if (bus_wr && bus_addr == REG_IEN) ien <= bus_wdata[LVL_LSB+3:LVL_LSB];
            ovr <= ovr_evt || (ovr && !(wr_stat && bus_wdata[STAT_OVER]));
            und <= und_evt || (und && !(wr_stat && bus_wdata[STAT_UNDER]));
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL:   bus_rdata[CTRL_RX_EN] = rx_en;
            REG_STAT: begin
                bus_rdata[LVL_LSB+3:LVL_LSB] = ~lv;
                bus_rdata[STAT_UNDER]        = und;
                bus_rdata[STAT_OVER]         = ovr;
            end
            REG_THRESH: bus_rdata = {8'h00, af_lvl, ae_lvl};
            REG_DATA:   bus_rdata = lv.empty ? '0 : 32'(head);
            REG_IEN:    bus_rdata[LVL_LSB+3:LVL_LSB] = ien;
            REG_IPEND:  bus_rdata[LVL_LSB+3:LVL_LSB] = pend;
            REG_SIZE:   bus_rdata[19:0] = 20'(DEPTH);
            REG_LEVEL:  bus_rdata = 32'(count);
            default:    bus_rdata = '0;
        endcase
    end

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !board_rst && !(wr_stat && bus_wdata[STAT_OVER])) |=> ovr);

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && !bus_rd && !bus_wr) |=> (count == CW'(DEPTH)));

    // R2
    settle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (count == '0));

    // R8
    und_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == REG_DATA && !busy && count == '0 && !bus_wr) |=> und);

endmodule

// File: tb/test_rxf_frontend.sv
module test_rxf_frontend;
    localparam int DEPTH  = 16;
    localparam int SETTLE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] sb_q[$];

    always #5 clk = ~clk;

    rxf_frontend #(.DW(32), .DEPTH(DEPTH), .SETTLE(SETTLE)) i_rxf_frontend (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rreg(a, v);
        chk(v, exp, tag);
    endtask

    // driver: offers one word, scoreboard gets it only if it should be accepted
    task automatic push_word(input logic [31:0] d, input bit accept);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        if (accept) sb_q.push_back(d);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop_word();
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'd3;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compares every data read against the scoreboard (R4, R8)
    always begin
        @(negedge clk);
        #1;
        if (bus_rd && bus_addr == 3'd3) begin
            if (sb_q.size() > 0) chk(bus_rdata, sb_q.pop_front(), "R4 order");
            else                 chk(bus_rdata, 32'h0, "R8 empty read data");
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        expect_reg(3'd1, 32'h0000C000, "R5 reset status");
        expect_reg(3'd0, 32'h0, "R1 reset ctrl");
        expect_reg(3'd5, 32'h0, "R9 reset pending");
        expect_reg(3'd6, 32'(DEPTH), "R11 size");
        chk({31'b0, irq}, 32'h0, "R10 reset irq");

        // disabled input ignored
        push_word(32'hDEAD0000, 1'b0);
        expect_reg(3'd7, 32'h0, "R4 disabled input ignored");

        wreg(3'd0, 32'h20);
        expect_reg(3'd0, 32'h20, "R4 enable readback");
        wreg(3'd2, 32'h00030002);
        expect_reg(3'd2, 32'h00030002, "R6 threshold fields");
        wreg(3'd4, 32'h4000);

        for (int i = 0; i < 5; i++) push_word(32'hA000 + i, 1'b1);
        expect_reg(3'd1, 32'h0000F000, "R5 mid level");
        expect_reg(3'd5, 32'h0, "R9 no rise yet");
        for (int i = 5; i < 13; i++) push_word(32'hA000 + i, 1'b1);
        expect_reg(3'd5, 32'h4000, "R9 almost full rise");
        expect_reg(3'd1, 32'h0000B000, "R5 almost full");
        chk({31'b0, irq}, 32'h1, "R10 irq on enabled source");
        for (int i = 13; i < 16; i++) push_word(32'hA000 + i, 1'b1);
        push_word(32'hBAD0BAD0, 1'b0);
        expect_reg(3'd7, 32'd16, "R7 level held at full");
        expect_reg(3'd1, 32'h00803000, "R7 overrun sticky");
        expect_reg(3'd5, 32'hC000, "R9 full rise");
        wreg(3'd5, 32'hF000);
        expect_reg(3'd5, 32'h0, "R9 w1c no re-set while held");
        chk({31'b0, irq}, 32'h0, "R10 irq after clear");
        wreg(3'd1, 32'h00800000);
        expect_reg(3'd1, 32'h00003000, "R7 overrun cleared");

        for (int i = 0; i < 16; i++) pop_word();
        expect_reg(3'd7, 32'h0, "R11 level after drain");
        expect_reg(3'd5, 32'h3000, "R9 empty and almost-empty rise");
        chk({31'b0, irq}, 32'h0, "R10 masked sources");
        wreg(3'd4, 32'h1000);
        chk({31'b0, irq}, 32'h1, "R10 irq after enable");

        pop_word();
        expect_reg(3'd1, 32'h0040C000, "R8 underrun set");
        expect_reg(3'd7, 32'h0, "R8 level unchanged");
        wreg(3'd1, 32'h00400000);
        expect_reg(3'd1, 32'h0000C000, "R8 underrun cleared");
        wreg(3'd5, 32'hF000);

        // FIFO reset keeps configuration
        for (int i = 0; i < 3; i++) push_word(32'hC000 + i, 1'b0);
        expect_reg(3'd7, 32'd3, "R3 level before flush");
        wreg(3'd0, 32'h24);
        expect_reg(3'd7, 32'h0, "R3 flush empties");
        expect_reg(3'd0, 32'h20, "R3 ctrl readback");
        expect_reg(3'd2, 32'h00030002, "R3 thresholds kept");
        expect_reg(3'd4, 32'h1000, "R3 enable mask kept");
        expect_reg(3'd5, 32'h3000, "R9 rise after flush");

        // board reset and settling window
        wreg(3'd0, 32'h01);
        expect_reg(3'd0, 32'h0, "R1 ctrl cleared");
        wreg(3'd0, 32'h20);
        push_word(32'hEE000001, 1'b0);
        push_word(32'hEE000002, 1'b0);
        expect_reg(3'd7, 32'h0, "R2 input ignored while settling");
        expect_reg(3'd2, 32'h0, "R1 thresholds cleared");
        expect_reg(3'd4, 32'h0, "R1 enables cleared");
        expect_reg(3'd5, 32'h0, "R1 pending cleared");
        chk({31'b0, irq}, 32'h0, "R1 irq low");
        repeat (SETTLE + 2) @(negedge clk);
        push_word(32'h5A5A1234, 1'b1);
        expect_reg(3'd7, 32'd1, "R2 accepted after window");
        pop_word();
        expect_reg(3'd7, 32'h0, "R2 drained");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule